// File: doc/BRIEF.md
# Serial Audio Input Receiver

This block receives stereo audio from three external wires and turns it into parallel samples: a bit clock, a frame clock that marks which channel is on the line, and a serial data line. Each channel carries one 24-bit two's complement sample, most significant bit first. A format input chooses between two framings. In MSB-justified framing the first bit of a slot is the MSB, and the left channel is sent while the frame clock is high. In I2S framing the MSB comes one bit clock later, and the left channel is sent while the frame clock is low.

Capture runs in the bit-clock domain. A slot may be anywhere from 24 to 32 bit clocks long. Bits past the 24th data bit of a slot are dropped. A slot that carries fewer than 24 data bits gives a left-aligned word with zeros in the missing low bits. When a frame's right channel is complete, the pair moves to the system clock domain through a toggle and a two-flop synchronizer. There the two words and a one-cycle valid strobe are registered together.

Top module: `serial_audio_rx`

## Requirements
- R1: Serial data is sampled only on the rising edge of the bit clock. The level of the data line while the bit clock is high has no effect.
- R2: With `fmt_i` = 0 (MSB-justified), the first bit-clock rising edge after a frame-clock change carries bit 23. The left word is taken from the half-frame where the frame clock is 1.
- R3: With `fmt_i` = 1 (I2S), the first rising edge after a frame-clock change is skipped and the second carries bit 23. The left word is taken from the half-frame where the frame clock is 0.
- R4: In a 32-clock slot, all bits after the 24th data bit are ignored, whatever their value.
- R5: Slot widths from 24 to 32 bit clocks per channel give correct words in both formats.
- R6: When a slot holds fewer than 24 data bits, the received bits fill the word from bit 23 downward and the missing low bits read 0. An I2S slot of 24 clocks therefore loses bit 0.
- R7: `left_o` and `right_o` change only in the cycle where `valid_o` is 1. `valid_o` is 1 for exactly one system clock per frame, and this happens after the frame's right channel has ended.
- R8: While `rst_i` is high, the outputs read zero and `valid_o` is 0. After reset, a frame is delivered only if its left half began with an observed frame-clock change, so a partial first half-frame is dropped.
- R9: Sample values pass through bit-exact, including the extremes 0x7FFFFF and 0x800000 and zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset; must span rising edges of both clocks |
| bclk_i | input | 1 | Serial bit clock |
| lrck_i | input | 1 | Frame (channel select) clock |
| sdata_i | input | 1 | Serial audio data |
| fmt_i | input | 1 | Framing select: 0 MSB-justified, 1 I2S |
| left_o | output | 24 | Left sample of the last complete frame |
| right_o | output | 24 | Right sample of the last complete frame |
| valid_o | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
The assertions assume four things about the inputs. The frame clock and data change only away from a rising bit-clock edge. `fmt_i` is constant outside reset. Reset spans rising edges of both clocks. Frames are far longer than the three-flop synchronizer latency, so two toggles never fall within one handoff. The stimulus drives the frame clock and data on the falling bit-clock edge and reverses the data line halfway through each high phase. It changes format only under reset and pulses the bit clock during reset. Its slowest frame is hundreds of system clocks long.

// File: rtl/sarx_pkg.sv
`timescale 1ns/1ps
package sarx_pkg;
  localparam int unsigned SAMPLE_W = 24;
  localparam int unsigned SLOT_MAX = 32;

  typedef enum logic {
    FMT_LEFTJ = 1'b0,
    FMT_I2S   = 1'b1
  } fmt_e;
endpackage

// File: rtl/sarx_framer.sv
`timescale 1ns/1ps
module sarx_framer
  import sarx_pkg::*;
#(
  parameter int unsigned MAX_SLOT = SLOT_MAX,
  localparam int unsigned CNT_W = $clog2(MAX_SLOT + 1)
) (
  input  logic             bclk_i,
  input  logic             rst_i,
  input  logic             lrck_i,
  input  logic             fmt_i,
  output logic             edge_o,
  output logic [CNT_W-1:0] pos_o,
  output logic             end_left_o,
  output logic             started_o
);
  localparam logic [CNT_W-1:0] POS_SAT = CNT_W'(MAX_SLOT);

  logic             lr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             started_q;

  always_comb begin
    edge_o     = lrck_i ^ lr_q;
    pos_o      = edge_o ? '0 : cnt_q;
    end_left_o = (fmt_i == FMT_I2S) ? ~lr_q : lr_q;
    started_o  = started_q;
  end

  always_ff @(posedge bclk_i) begin
    if (rst_i) begin
      lr_q      <= lrck_i;
      cnt_q     <= POS_SAT;
      started_q <= 1'b0;
    end else begin
      lr_q <= lrck_i;
      if (edge_o) begin
        cnt_q     <= CNT_W'(1);
        started_q <= 1'b1;
      end else if (cnt_q != POS_SAT) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  AST_STARTED_STICKY: assert property (@(posedge bclk_i) disable iff (rst_i)
    started_q |=> started_q) else $error("started flag dropped"); // R8
endmodule

// File: rtl/sarx_assemble.sv
`timescale 1ns/1ps
module sarx_assemble
  import sarx_pkg::*;
#(
  parameter int unsigned WORD_W = SAMPLE_W,
  parameter int unsigned CNT_W  = 6
) (
  input  logic              bclk_i,
  input  logic              rst_i,
  input  logic              sdata_i,
  input  logic              fmt_i,
  input  logic              edge_i,
  input  logic [CNT_W-1:0]  pos_i,
  input  logic              end_left_i,
  input  logic              started_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              tog_o
);
  logic [WORD_W-1:0] acc_q, acc_base, acc_nx;
  logic [WORD_W-1:0] lhold_q, left_q, right_q;
  logic              left_ok_q, tog_q;
  int                k_val;
  logic              take;

  always_comb begin
    k_val    = int'(pos_i) - int'(fmt_i);
    take     = (k_val >= 0) && (k_val < int'(WORD_W));
    acc_base = edge_i ? '0 : acc_q;
  end

  for (genvar b = 0; b < int'(WORD_W); b++) begin : g_bit
    assign acc_nx[b] = (take && (k_val == int'(WORD_W) - 1 - b)) ? sdata_i : acc_base[b];
  end

  always_ff @(posedge bclk_i) begin
    if (rst_i) begin
      acc_q     <= '0;
      lhold_q   <= '0;
      left_q    <= '0;
      right_q   <= '0;
      left_ok_q <= 1'b0;
      tog_q     <= 1'b0;
    end else begin
      acc_q <= acc_nx;
      if (edge_i && started_i) begin
        if (end_left_i) begin
          lhold_q   <= acc_q;
          left_ok_q <= 1'b1;
        end else begin
          left_ok_q <= 1'b0;
          if (left_ok_q) begin
            left_q  <= lhold_q;
            right_q <= acc_q;
            tog_q   <= ~tog_q;
          end
        end
      end
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
  assign tog_o   = tog_q;

  AST_I2S_SKIP_FIRST: assert property (@(posedge bclk_i) disable iff (rst_i)
    (edge_i && fmt_i) |=> (acc_q == '0)) else $error("I2S first bit captured"); // R3
  AST_TOGGLE_AFTER_RIGHT: assert property (@(posedge bclk_i) disable iff (rst_i)
    !(edge_i && !end_left_i) |=> $stable(tog_q)) else $error("handoff outside right end"); // R7
endmodule

// File: rtl/sarx_cdc.sv
`timescale 1ns/1ps
module sarx_cdc #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              tog_i,
  input  logic [WORD_W-1:0] left_i,
  input  logic [WORD_W-1:0] right_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);
  logic [2:0]        sync_q;
  logic              pulse;
  logic [WORD_W-1:0] left_q, right_q;
  logic              valid_q;

  assign pulse = sync_q[1] ^ sync_q[2];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sync_q  <= '0;
      left_q  <= '0;
      right_q <= '0;
      valid_q <= 1'b0;
    end else begin
      sync_q  <= {sync_q[1:0], tog_i};
      valid_q <= pulse;
      if (pulse) begin
        left_q  <= left_i;
        right_q <= right_i;
      end
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
  assign valid_o = valid_q;

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_q |=> !valid_q) else $error("valid longer than one cycle"); // R7
  AST_WORDS_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
    !valid_q |-> ($stable(left_q) && $stable(right_q))) else $error("words moved without valid"); // R7
endmodule

// File: rtl/serial_audio_rx.sv
`timescale 1ns/1ps
module serial_audio_rx
  import sarx_pkg::*;
#(
  parameter int unsigned WORD_W   = SAMPLE_W,
  parameter int unsigned MAX_SLOT = SLOT_MAX,
  localparam int unsigned CNT_W   = $clog2(MAX_SLOT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              bclk_i,
  input  logic              lrck_i,
  input  logic              sdata_i,
  input  logic              fmt_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);
  logic             edge_w, end_left_w, started_w, tog_w;
  logic [CNT_W-1:0] pos_w;
  logic [WORD_W-1:0] frame_l, frame_r;

  sarx_framer #(.MAX_SLOT(MAX_SLOT)) u_framer (
    .bclk_i(bclk_i), .rst_i(rst_i), .lrck_i(lrck_i), .fmt_i(fmt_i),
    .edge_o(edge_w), .pos_o(pos_w), .end_left_o(end_left_w), .started_o(started_w)
  );

  sarx_assemble #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_assemble (
    .bclk_i(bclk_i), .rst_i(rst_i), .sdata_i(sdata_i), .fmt_i(fmt_i),
    .edge_i(edge_w), .pos_i(pos_w), .end_left_i(end_left_w), .started_i(started_w),
    .left_o(frame_l), .right_o(frame_r), .tog_o(tog_w)
  );

  sarx_cdc #(.WORD_W(WORD_W)) u_cdc (
    .clk_i(clk_i), .rst_i(rst_i), .tog_i(tog_w),
    .left_i(frame_l), .right_i(frame_r),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );
endmodule

// File: tb/serial_audio_rx_bench.sv
`timescale 1ns/1ps
module serial_audio_rx_bench;
  logic clk = 1'b0, rst = 1'b1, bclk = 1'b0, lrck = 1'b0, sdata = 1'b0, fmt = 1'b0;
  logic [23:0] left_o, right_o;
  logic        valid_o;

  int n_chk = 0, n_err = 0, stab_err = 0;
  logic [23:0] exp_l[$], exp_r[$];
  string       exp_tag[$];
  logic        prev_v = 1'b0;
  logic [23:0] prev_l = '0, prev_r = '0;
  logic [31:0] seed = 32'h1234_5678;
  bit          done = 1'b0;

  serial_audio_rx u_serial_audio_rx (
    .clk_i(clk), .rst_i(rst), .bclk_i(bclk), .lrck_i(lrck), .sdata_i(sdata),
    .fmt_i(fmt), .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  always #2.5 clk = ~clk;

  // One bit clock; data is reversed while bclk is high so only the rising edge may matter (R1).
  task automatic tick();
    #10 bclk = 1'b1;
    #5  sdata = ~sdata;
    #5  bclk = 1'b0;
  endtask

  function automatic logic [23:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[31:8];
  endfunction

  function automatic logic [23:0] keep_mask(input int slot, input logic f);
    logic [23:0] m = '1;
    int kept = slot - int'(f);
    if (kept < 24) m = m << (24 - kept);
    return m;
  endfunction

  task automatic send_half(input logic lvl, input logic [23:0] w, input int slot, input logic f);
    for (int i = 0; i < slot; i++) begin
      int k;
      k = i - int'(f);
      lrck  = lvl;
      sdata = (k >= 0 && k < 24) ? w[23 - k] : 1'b1;
      tick();
    end
  endtask

  task automatic send_frame(input logic f, input int slot, input logic [23:0] l,
                            input logic [23:0] r, input string tag);
    logic lv = f ? 1'b0 : 1'b1;
    exp_l.push_back(l & keep_mask(slot, f));
    exp_r.push_back(r & keep_mask(slot, f));
    exp_tag.push_back(tag);
    send_half(lv, l, slot, f);
    send_half(~lv, r, slot, f);
  endtask

  task automatic do_reset(input logic f, input logic lr_level);
    rst = 1'b1; fmt = f; lrck = lr_level; sdata = 1'b0;
    repeat (3) tick();
    @(posedge clk); #1 rst = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  // Starts a left half so the last right half is committed, then waits for the handoff.
  task automatic flush(input logic f, input string tag);
    lrck = f ? 1'b0 : 1'b1; sdata = 1'b0;
    tick(); tick();
    repeat (40) @(posedge clk);
    n_chk++;
    if (exp_l.size() != 0) begin
      n_err++;
      $display("FAIL %s: frames delivered actual=%0d missing expected=0", tag, exp_l.size());
      exp_l.delete(); exp_r.delete(); exp_tag.delete();
    end
  endtask

  always @(negedge clk) begin
    if (!rst && valid_o) begin
      if (prev_v) begin
        n_chk++; n_err++;
        $display("FAIL R7: valid width actual=2+ expected=1");
      end
      n_chk++;
      if (exp_l.size() == 0) begin
        n_err++;
        $display("FAIL R8: unexpected frame actual=%h/%h expected=none", left_o, right_o);
      end else begin
        logic [23:0] el, er;
        string t;
        el = exp_l.pop_front(); er = exp_r.pop_front(); t = exp_tag.pop_front();
        if (left_o !== el || right_o !== er) begin
          n_err++;
          $display("FAIL %s: words actual=%h/%h expected=%h/%h", t, left_o, right_o, el, er);
        end
      end
    end else if (!rst && !valid_o && (left_o !== prev_l || right_o !== prev_r)) begin
      stab_err++;
    end
    prev_v = valid_o; prev_l = left_o; prev_r = right_o;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int slots[5] = '{24, 25, 28, 32, 20};
    // R8: reset state
    rst = 1'b1; lrck = 1'b0;
    repeat (3) tick();
    @(negedge clk);
    n_chk++;
    if (left_o !== '0 || right_o !== '0 || valid_o !== 1'b0) begin
      n_err++;
      $display("FAIL R8: reset outputs actual=%h/%h/%b expected=0/0/0", left_o, right_o, valid_o);
    end

    for (int fi = 0; fi < 2; fi++) begin
      for (int si = 0; si < 5; si++) begin
        logic f = fi[0];
        int slot = slots[si];
        string rtag;
        do_reset(f, f ? 1'b1 : 1'b0);
        // R9 extremes
        send_frame(f, slot, 24'h7FFFFF, 24'h800000, "R9");
        send_frame(f, slot, 24'h000000, 24'hFFFFFF, "R9");
        send_frame(f, slot, 24'h800000, 24'h7FFFFF, "R9");
        // R2 / R3 walking bits
        for (int b = 0; b < 24; b += 5)
          send_frame(f, slot, 24'h1 << b, ~(24'h1 << b), f ? "R3" : "R2");
        if (slot - fi < 24) rtag = "R6";
        else if (slot == 32) rtag = "R4";
        else if (slot == 28) rtag = "R5";
        else rtag = "R1";
        for (int n = 0; n < 3; n++) send_frame(f, slot, rnd(), rnd(), rtag);
        flush(f, "R7");
      end
    end

    // R8: reset with frame clock at the left level; the partial left half and its right are dropped
    do_reset(1'b0, 1'b1);
    send_half(1'b1, 24'hABCDEF, 10, 1'b0);
    send_half(1'b0, 24'h123456, 32, 1'b0);
    send_frame(1'b0, 32, 24'h5A5A5A, 24'hA5A5A5, "R8");
    flush(1'b0, "R8");

    n_chk++;
    if (stab_err != 0) begin
      n_err++;
      $display("FAIL R7: output changes without valid actual=%0d expected=0", stab_err);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule